// File: doc/BRIEF.md
# Sliced Ripple Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It is assembled from a chain of identical one-bit slices. It takes two operands of a parameterised width (default 4) and a 3-bit operation code, and it returns a result of the same width together with a carry-out. Each slice holds three parts: a four-way selector that forms the adder's second operand, a full adder, and a logic unit. A final two-way choice in the slice picks either the arithmetic or the logic output. Carries ripple from the least significant slice towards the most significant slice.

All four arithmetic operations share one adder. The low two opcode bits select what the adder sees in place of B. The middle opcode bit also serves directly as the carry into the lowest slice, so no separate decoder drives it. The top opcode bit switches the whole unit to bitwise logic. In logic mode the carry-out is held at zero.

Top module: `slice_alu`

## Requirements
- R1: Opcode 001 (op_i[1:0]=01 makes the adder see B, carry-in 0) gives y_o = (A+B) mod 2^W, and cout_o is bit W of the full sum A+B.
- R2: Opcode 000 (adder sees all ones, carry-in 0) gives y_o = (A-1) mod 2^W, and cout_o = 1 unless A is zero.
- R3: Opcode 010 (adder sees inverted B, carry-in 1) gives y_o = (A-B) mod 2^W, and cout_o = 1 exactly when A >= B (no borrow).
- R4: Opcode 011 (adder sees zero, carry-in 1) gives y_o = (A+1) mod 2^W, and cout_o = 1 exactly when A is all ones.
- R5: Opcode 100 gives y_o = A AND B.
- R6: Opcode 101 gives y_o = A XOR B.
- R7: Opcode 110 gives y_o = A XNOR B.
- R8: Opcode 111 gives y_o = A OR B.
- R9: When op_i[2]=1 (logic mode), cout_o = 0 for every operand pair, and the carry-in set by op_i[1] has no effect on y_o.
- R10: The carry into the lowest slice equals op_i[1]. This is seen at the ports: subtracting equal operands gives zero with cout_o=1, and incrementing zero gives 1.
- R11: With A=1100 and B=0101 the outputs {cout_o,y_o} are: 000 → 1,1011; 001 → 1,0001; 010 → 1,0111; 011 → 0,1101; 100 → 0,0100; 101 → 0,1001; 110 → 0,0110; 111 → 0,1101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code; bit 2 picks logic mode, bits 1:0 pick operand or logic function |
| y_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry from the most significant slice in arithmetic mode, zero in logic mode |

## Verification
Whenever the inputs change, the bound checker tests the full-width sum, the difference with its no-borrow carry, the AND result and the zero carry-out in logic mode. Each of these is compared against arithmetic on the ports as a whole, not slice by slice. The bench's exhaustive sweep alone shows that decrement, increment, XOR, XNOR and OR are correct for every operand pair. Only the bench's scenarios show that the carry-in tied to op_i[1] is visible on subtract and increment, and that the fixed operand pair yields the expected value for every opcode.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

   // Second adder operand chosen by op[1:0] in arithmetic mode
   typedef enum logic [1:0] {
      OPND_ONES = 2'b00,
      OPND_B    = 2'b01,
      OPND_NB   = 2'b10,
      OPND_ZERO = 2'b11
   } opnd_sel_e;

   // Bitwise function chosen by op[1:0] in logic mode
   typedef enum logic [1:0] {
      LOG_AND  = 2'b00,
      LOG_XOR  = 2'b01,
      LOG_XNOR = 2'b10,
      LOG_OR   = 2'b11
   } logic_sel_e;

   localparam int OP_W = 3;

endpackage

// File: rtl/slice_alu_opnd_mux.sv
module slice_alu_opnd_mux
   import slice_alu_pkg::*;
(
   input  logic       b_i,
   input  logic [1:0] sel_i,
   output logic       opnd_o
);

   always_comb begin
      unique case (opnd_sel_e'(sel_i))
         OPND_ONES: opnd_o = 1'b1;
         OPND_B:    opnd_o = b_i;
         OPND_NB:   opnd_o = ~b_i;
         OPND_ZERO: opnd_o = 1'b0;
         default:   opnd_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/slice_alu_fa.sv
module slice_alu_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   logic half;

   assign half = x_i ^ y_i;
   assign s_o  = half ^ c_i;
   assign c_o  = (x_i & y_i) | (half & c_i);

endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
   import slice_alu_pkg::*;
(
   input  logic            a_i,
   input  logic            b_i,
   input  logic [OP_W-1:0] op_i,
   input  logic            cin_i,
   output logic            y_o,
   output logic            cout_o
);

   logic opnd;
   logic sum;
   logic lres;

   slice_alu_opnd_mux u_mux (
      .b_i    (b_i),
      .sel_i  (op_i[1:0]),
      .opnd_o (opnd)
   );

   slice_alu_fa u_fa (
      .x_i (a_i),
      .y_i (opnd),
      .c_i (cin_i),
      .s_o (sum),
      .c_o (cout_o)
   );

   always_comb begin
      unique case (logic_sel_e'(op_i[1:0]))
         LOG_AND:  lres = a_i & b_i;
         LOG_XOR:  lres = a_i ^ b_i;
         LOG_XNOR: lres = ~(a_i ^ b_i);
         LOG_OR:   lres = a_i | b_i;
         default:  lres = 1'b0;
      endcase
   end

   assign y_o = op_i[2] ? lres : sum;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import slice_alu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] y_o,
   output logic             cout_o
);

   localparam int CHAIN_W = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("slice_alu: WIDTH must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] carry;

   // Carry into the lowest slice is the middle opcode bit itself
   assign carry[0] = op_i[1];

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         slice_alu_bit u_bit (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .op_i   (op_i),
            .cin_i  (carry[i]),
            .y_o    (y_o[i]),
            .cout_o (carry[i+1])
         );
      end
   endgenerate

   assign cout_o = op_i[2] ? 1'b0 : carry[WIDTH];

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] y_o,
   input logic             cout_o
);

   logic [WIDTH:0] ext_a;
   logic [WIDTH:0] ext_b;

   assign ext_a = {1'b0, a_i};
   assign ext_b = {1'b0, b_i};

   always_comb begin
      if (op_i == 3'b001) begin
         a_r1_add_sum : assert ({cout_o, y_o} == ext_a + ext_b)
            else $error("R1 add mismatch");
      end
      if (op_i == 3'b010) begin
         a_r3_sub_diff : assert (y_o == a_i - b_i && cout_o == (a_i >= b_i))
            else $error("R3 subtract mismatch");
      end
      if (op_i == 3'b100) begin
         a_r5_and_bits : assert (y_o == (a_i & b_i))
            else $error("R5 and mismatch");
      end
      if (op_i[2]) begin
         a_r9_logic_no_carry : assert (cout_o == 1'b0)
            else $error("R9 carry-out set in logic mode");
      end
   end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .op_i   (op_i),
   .y_o    (y_o),
   .cout_o (cout_o)
);

// File: tb/sim_slice_alu.sv
module sim_slice_alu;

   localparam int W        = 4;
   localparam int CLK_PER  = 10;
   localparam int WD_LIMIT = 100000;
   localparam logic [W-1:0] ONES = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  a, b, y;
   logic [2:0]    op;
   logic          cout;
   int            n_chk = 0;
   int            n_err = 0;
   int            cycles = 0;

   always #(CLK_PER/2) clk = ~clk;

   slice_alu #(.WIDTH(W)) u0 (
      .a_i(a), .b_i(b), .op_i(op), .y_o(y), .cout_o(cout)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT) begin
         n_err = n_err + 1;
         $display("FAIL watchdog: cycles %0d expected < %0d", cycles, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   function automatic logic [W:0] ref_out(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] z);
      case (o)
         3'b000: ref_out = {(x != '0), W'(x - 1'b1)};
         3'b001: ref_out = {1'b0, x} + {1'b0, z};
         3'b010: ref_out = {(x >= z), W'(x - z)};
         3'b011: ref_out = {(x == ONES), W'(x + 1'b1)};
         3'b100: ref_out = {1'b0, x & z};
         3'b101: ref_out = {1'b0, x ^ z};
         3'b110: ref_out = {1'b0, ~(x ^ z)};
         default: ref_out = {1'b0, x | z};
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'b000: req_of = "R2";
         3'b001: req_of = "R1";
         3'b010: req_of = "R3";
         3'b011: req_of = "R4";
         3'b100: req_of = "R5";
         3'b101: req_of = "R6";
         3'b110: req_of = "R7";
         default: req_of = "R8";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] z);
      @(posedge clk);
      op = o; a = x; b = z;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
      n_chk = n_chk + 1;
      if (got !== exp) begin
         n_err = n_err + 1;
         $display("FAIL %s: op=%b a=%b b=%b got %b expected %b", req, op, a, b, got, exp);
      end
   endtask

   task automatic t_reset;
      // R2: idle inputs all zero select decrement of zero
      apply(3'b000, '0, '0);
      check("R2 reset state", {cout, y}, {1'b0, ONES});
   endtask

   task automatic t_fixed_pair;
      logic [W:0] exp_tab [8];
      exp_tab[0] = 5'b1_1011; exp_tab[1] = 5'b1_0001;
      exp_tab[2] = 5'b1_0111; exp_tab[3] = 5'b0_1101;
      exp_tab[4] = 5'b0_0100; exp_tab[5] = 5'b0_1001;
      exp_tab[6] = 5'b0_0110; exp_tab[7] = 5'b0_1101;
      for (int o = 0; o < 8; o++) begin
         apply(3'(o), 4'b1100, 4'b0101);
         check("R11 fixed pair", {cout, y}, exp_tab[o]);
      end
   endtask

   task automatic t_sweep_arith;
      for (int o = 0; o < 4; o++)
         for (int x = 0; x < (1 << W); x++)
            for (int z = 0; z < (1 << W); z++) begin
               apply(3'(o), W'(x), W'(z));
               check(req_of(3'(o)), {cout, y}, ref_out(3'(o), W'(x), W'(z)));
            end
   endtask

   task automatic t_sweep_logic;
      for (int o = 4; o < 8; o++)
         for (int x = 0; x < (1 << W); x++)
            for (int z = 0; z < (1 << W); z++) begin
               apply(3'(o), W'(x), W'(z));
               check(req_of(3'(o)), {cout, y}, ref_out(3'(o), W'(x), W'(z)));
               // R9: carry-out stays zero in logic mode
               check("R9 logic carry", {W'(0), cout}, '0);
            end
   endtask

   task automatic t_carry_in;
      // R10: carry-in tied to op[1] seen on subtract of equal operands and increment of zero
      apply(3'b010, 4'b1010, 4'b1010);
      check("R10 sub equal", {cout, y}, {1'b1, W'(0)});
      apply(3'b011, '0, 4'b0110);
      check("R10 inc zero", {cout, y}, {1'b0, W'(1)});
      apply(3'b001, 4'b0000, 4'b0000);
      check("R10 add no cin", {cout, y}, '0);
      // R9: op[1] differs between AND and XNOR rows but never adds a carry into the result
      apply(3'b110, ONES, ONES);
      check("R9 xnor cin ignored", {cout, y}, {1'b0, ONES});
   endtask

   initial begin
      a = '0; b = '0; op = '0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed_pair();
      t_carry_in();
      t_sweep_arith();
      t_sweep_logic();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule